// File: doc/BRIEF.md
# Attribute-Configurable Register Field Bank

This block is a compact bank of control and status registers. Each word-wide field takes its software access behaviour from a per-field parameter code. The kinds on offer are: sticky storage that survives a warm reset, read/write storage that hardware may clear, the same with writes gated by a lock, status bits that software clears by writing ones, storage that takes its first write only, write-only command words that emit a pulse, and the lock word itself. Software reaches the fields over a plain register bus with an address, write data, byte enables, a write strobe and a read strobe. Read data comes back one cycle after the read strobe.

On the hardware side, each field bit has a clear-event input and a set-event input. A field uses them only if its kind calls for them. The current stored value of every field is driven out, and each write-only field drives a pulse together with the written data. The bank has two synchronous active-low resets. The cold (power-good) reset returns every field to its default. The warm reset returns every field except the sticky ones.

Top module: `attr_reg_bank`

## Requirements
- R1: A sticky field (default map: address 0, default value 0x000000A5; address 7, default 0) is read/write, keeps its value through a warm reset, and returns to its default only on a cold reset.
- R2: A self-clearing field (address 1) is read/write. A 1 on its hw_clr bit clears that bit on the next edge. When a clear event and a software write of 1 hit the same bit in the same cycle, the bit ends at 0.
- R3: The lock field (address 2) accepts writes that set bits only. Writing 0 never clears a set bit, and either reset clears it. Its bit 0 is the lock.
- R4: The lockable self-clearing field (address 3) behaves as in R2 while the lock bit is 0. While the lock bit is 1, software writes leave it unchanged, but hw_clr still clears bits.
- R5: In the write-one-to-clear field (address 4), writing 1 clears that bit, writing 0 leaves it, and a 1 on hw_set sets the bit. When a set and a clear hit the same bit in the same cycle, the bit ends at 1.
- R6: The write-once field (address 5) takes the first write that has at least one byte enable set and ignores all later writes until a warm or cold reset. A write with no byte enable set neither changes it nor uses up its one write.
- R7: The write-only field (address 6) always reads 0. A write to it with any byte enable set raises its wo_pulse bit (bit 6) in that same cycle only, and wo_data carries the write data with disabled bytes forced to 0.
- R8: A write changes only the bytes whose bus_be bit is 1. Bit k of bus_be covers data bits 8k+7..8k.
- R9: bus_rdata returns the addressed field in the cycle after bus_rd, showing the value from before any write in that same cycle. Addresses 8 and above read 0, and bus_rdata is 0 in any cycle that does not follow a read strobe.
- R10: field_q carries field i in bits 32i+31..32i and reflects each completed write on the next edge. The write-only field shows 0.
- R11: Event inputs have no effect on fields whose kind does not use them. A sticky field ignores hw_clr, and a self-clearing field ignores hw_set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold / power-good reset, synchronous, active low |
| rst_warm_n | input | 1 | Warm reset, synchronous, active low |
| bus_addr | input | ADDR_W | Word address of the field |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| hw_clr | input | NUM_FIELDS*DATA_W | Per-bit hardware clear events |
| hw_set | input | NUM_FIELDS*DATA_W | Per-bit hardware set events |
| field_q | output | NUM_FIELDS*DATA_W | Current value of every field |
| wo_pulse | output | NUM_FIELDS | Write-side-effect strobe per field |
| wo_data | output | NUM_FIELDS*DATA_W | Data that goes with each strobe |

## Verification
Each field kind is driven with a lone software write, a lone hardware event, and the two landing in the same cycle. These cases separate a design that gives priority to the wrong side from one that honours R2 and R5. Writes with partial and empty byte enables tell apart correct masking and the write-once flag from whole-word or enable-blind handling. Warm and cold resets are applied with non-default values stored, so the sticky fields are shown to differ from the rest. Reads that share a cycle with a write, reads of unmapped addresses, and idle cycles pin down the read timing.

// File: rtl/attr_reg_pkg.sv
// Package: shared access-kind codes for the register field bank.
// Assumes a 3-bit code per field, packed into the top's KIND_MAP parameter.
package attr_reg_pkg;

    typedef enum logic [2:0] {
        KIND_STICKY  = 3'd0,  // rw, survives warm reset
        KIND_SELFCLR = 3'd1,  // rw, hardware clear event
        KIND_LOCKSC  = 3'd2,  // as SELFCLR, writes gated by lock
        KIND_W1C     = 3'd3,  // write one to clear, hardware set
        KIND_WONCE   = 3'd4,  // first write taken, then read only
        KIND_WONLY   = 3'd5,  // reads zero, write emits pulse
        KIND_LOCK    = 3'd6   // set-only lock word
    } field_kind_e;

endpackage

// File: rtl/attr_wr_decode.sv
// Write decode: turns the bus address and write strobe into one select
// per field, and expands the byte enables into a bit mask.
// Assumes DATA_W is a multiple of 8 and NUM_FIELDS <= 2**ADDR_W.
module attr_wr_decode #(
    parameter int NUM_FIELDS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4
) (
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W/8-1:0]   bus_be,
    input  logic                  bus_wr,
    output logic [NUM_FIELDS-1:0] wr_sel,
    output logic [DATA_W-1:0]     wmask
);

    localparam int BE_W = DATA_W / 8;

    // one select line per mapped word
    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(i));
        end
    end

    // each enable bit covers one byte lane of the mask
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign wmask[8*b +: 8] = {8{bus_be[b]}};
    end

endmodule

// File: rtl/attr_field.sv
// One register field whose access behaviour is fixed by KIND.
// Assumes wmask already holds the expanded byte enables, that wr_sel is
// high for a write to this field's address, and that lock_on is the lock bit.
module attr_field
    import attr_reg_pkg::*;
#(
    parameter logic [2:0]        KIND    = KIND_STICKY,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_cold_n,
    input  logic              rst_warm_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_clr,
    input  logic [DATA_W-1:0] hw_set,
    input  logic              lock_on,
    output logic [DATA_W-1:0] q,
    output logic              pulse,
    output logic [DATA_W-1:0] pulse_data
);

    localparam logic [DATA_W-1:0] INIT_VAL = (KIND == KIND_WONLY) ? '0 : RST_VAL;
    localparam bit                IS_STICKY = (KIND == KIND_STICKY);

    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] merged;
    logic              wr_hit;
    logic              used_once;
    logic              do_rst;

    assign merged = (q & ~wmask) | (wdata & wmask);
    assign wr_hit = wr_sel && (|wmask);
    // sticky fields answer only the cold reset
    assign do_rst = IS_STICKY ? !rst_cold_n : (!rst_cold_n || !rst_warm_n);

    // the write-once variant carries a flag, the others tie it off
    if (KIND == KIND_WONCE) begin : g_once
        // remember that the single allowed write has happened
        always_ff @(posedge clk) begin
            if (!rst_cold_n || !rst_warm_n) used_once <= 1'b0;
            else if (wr_hit)                used_once <= 1'b1;
        end
    end else begin : g_no_once
        assign used_once = 1'b0;
    end

    // next-state rule per access kind
    always_comb begin
        case (KIND)
            KIND_STICKY:  nxt = wr_sel ? merged : q;
            KIND_SELFCLR: nxt = (wr_sel ? merged : q) & ~hw_clr;
            KIND_LOCKSC:  nxt = ((wr_sel && !lock_on) ? merged : q) & ~hw_clr;
            KIND_W1C:     nxt = (wr_sel ? (q & ~(wdata & wmask)) : q) | hw_set;
            KIND_WONCE:   nxt = (wr_hit && !used_once) ? merged : q;
            KIND_LOCK:    nxt = wr_sel ? (q | (wdata & wmask)) : q;
            default:      nxt = '0;
        endcase
    end

    // field storage with kind-dependent reset domain
    always_ff @(posedge clk) begin
        if (do_rst) q <= INIT_VAL;
        else        q <= nxt;
    end

    // side-effect strobe for write-only fields, same cycle as the write
    always_comb begin
        pulse      = (KIND == KIND_WONLY) && wr_hit;
        pulse_data = pulse ? (wdata & wmask) : '0;
    end

endmodule

// File: rtl/attr_rd_mux.sv
// Read return: selects the addressed field and registers it for one cycle.
// Assumes fields are packed DATA_W apart and unmapped words read zero.
module attr_rd_mux #(
    parameter int NUM_FIELDS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_cold_n,
    input  logic                           rst_warm_n,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [NUM_FIELDS*DATA_W-1:0]   fields,
    output logic [DATA_W-1:0]              bus_rdata
);

    logic [DATA_W-1:0] pick;

    // choose the addressed word, zero when nothing matches
    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (bus_addr == ADDR_W'(i)) pick = fields[i*DATA_W +: DATA_W];
        end
    end

    // register the result, zero in cycles without a read strobe
    always_ff @(posedge clk) begin
        if (!rst_cold_n || !rst_warm_n) bus_rdata <= '0;
        else                            bus_rdata <= bus_rd ? pick : '0;
    end

endmodule

// File: rtl/attr_reg_bank.sv
// Top of the register field bank: write decode, one attr_field per mapped
// word, and the registered read path. Field i sits at word address i.
// Assumes KIND_MAP places the lock word at LOCK_IDX.
module attr_reg_bank
    import attr_reg_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int LOCK_IDX   = 2,
    parameter logic [3*NUM_FIELDS-1:0] KIND_MAP = {
        KIND_STICKY, KIND_WONLY, KIND_WONCE, KIND_W1C,
        KIND_LOCKSC, KIND_LOCK,  KIND_SELFCLR, KIND_STICKY},
    parameter logic [NUM_FIELDS*DATA_W-1:0] RST_MAP =
        {{((NUM_FIELDS-1)*DATA_W){1'b0}}, DATA_W'('hA5)}
) (
    input  logic                         clk,
    input  logic                         rst_cold_n,
    input  logic                         rst_warm_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [DATA_W/8-1:0]          bus_be,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_FIELDS*DATA_W-1:0] hw_clr,
    input  logic [NUM_FIELDS*DATA_W-1:0] hw_set,
    output logic [NUM_FIELDS*DATA_W-1:0] field_q,
    output logic [NUM_FIELDS-1:0]        wo_pulse,
    output logic [NUM_FIELDS*DATA_W-1:0] wo_data
);

    localparam int LOCK_BIT = LOCK_IDX * DATA_W;

    logic [NUM_FIELDS-1:0] wr_sel;
    logic [DATA_W-1:0]     wmask;
    logic                  lock_on;

    attr_wr_decode #(
        .NUM_FIELDS (NUM_FIELDS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wr   (bus_wr),
        .wr_sel   (wr_sel),
        .wmask    (wmask)
    );

    assign lock_on = field_q[LOCK_BIT];

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        attr_field #(
            .KIND    (KIND_MAP[3*f +: 3]),
            .DATA_W  (DATA_W),
            .RST_VAL (RST_MAP[f*DATA_W +: DATA_W])
        ) u_fld (
            .clk        (clk),
            .rst_cold_n (rst_cold_n),
            .rst_warm_n (rst_warm_n),
            .wr_sel     (wr_sel[f]),
            .wmask      (wmask),
            .wdata      (bus_wdata),
            .hw_clr     (hw_clr[f*DATA_W +: DATA_W]),
            .hw_set     (hw_set[f*DATA_W +: DATA_W]),
            .lock_on    (lock_on),
            .q          (field_q[f*DATA_W +: DATA_W]),
            .pulse      (wo_pulse[f]),
            .pulse_data (wo_data[f*DATA_W +: DATA_W])
        );
    end

    attr_rd_mux #(
        .NUM_FIELDS (NUM_FIELDS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W)
    ) u_rd (
        .clk        (clk),
        .rst_cold_n (rst_cold_n),
        .rst_warm_n (rst_warm_n),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .fields     (field_q),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: rtl/attr_reg_bank_chk.sv
// Checker for attr_reg_bank: temporal properties on its ports, bound below.
// Assumes the same parameters as the bound instance.
module attr_reg_bank_chk
    import attr_reg_pkg::*;
#(
    parameter int NUM_FIELDS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int LOCK_IDX   = 2,
    parameter logic [3*NUM_FIELDS-1:0] KIND_MAP = '0
) (
    input logic                         clk,
    input logic                         rst_cold_n,
    input logic                         rst_warm_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_FIELDS*DATA_W-1:0] hw_clr,
    input logic [NUM_FIELDS*DATA_W-1:0] hw_set,
    input logic [NUM_FIELDS*DATA_W-1:0] field_q,
    input logic [NUM_FIELDS-1:0]        wo_pulse
);

    logic any_rst;
    assign any_rst = !rst_cold_n || !rst_warm_n;

    // R9: unmapped reads and idle cycles return zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (any_rst)
        (bus_rd && (int'(bus_addr) >= NUM_FIELDS)) |=> (bus_rdata == '0));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (any_rst)
        !bus_rd |=> (bus_rdata == '0));

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_chk
        localparam logic [2:0] K = KIND_MAP[3*f +: 3];
        if (K == KIND_SELFCLR || K == KIND_LOCKSC) begin : g_sc
            // R2: a clear event always leaves its bit at zero
            assert_hw_clear_wins_R2: assert property (@(posedge clk) disable iff (any_rst)
                (|hw_clr[f*DATA_W +: DATA_W]) |=>
                ((field_q[f*DATA_W +: DATA_W] & $past(hw_clr[f*DATA_W +: DATA_W])) == '0));
        end
        if (K == KIND_LOCKSC) begin : g_lsc
            // R4: locked field ignores writes when no clear event is present
            assert_locked_ro_R4: assert property (@(posedge clk) disable iff (any_rst)
                (field_q[LOCK_IDX*DATA_W] && bus_wr && (bus_addr == ADDR_W'(f))
                 && (hw_clr[f*DATA_W +: DATA_W] == '0))
                |=> $stable(field_q[f*DATA_W +: DATA_W]));
        end
        if (K == KIND_W1C) begin : g_w1c
            // R5: a set event is never lost
            assert_set_kept_R5: assert property (@(posedge clk) disable iff (any_rst)
                (|hw_set[f*DATA_W +: DATA_W]) |=>
                (($past(hw_set[f*DATA_W +: DATA_W]) & ~field_q[f*DATA_W +: DATA_W]) == '0));
        end
        if (K == KIND_LOCK) begin : g_lock
            // R3: lock bits only rise outside reset
            assert_lock_holds_R3: assert property (@(posedge clk) disable iff (any_rst)
                (|field_q[f*DATA_W +: DATA_W]) |=>
                ((field_q[f*DATA_W +: DATA_W] & $past(field_q[f*DATA_W +: DATA_W]))
                 == $past(field_q[f*DATA_W +: DATA_W])));
        end
        if (K == KIND_STICKY) begin : g_sticky
            // R1: warm reset alone leaves a sticky field untouched
            assert_sticky_warm_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
                (!rst_warm_n && !bus_wr) |=> $stable(field_q[f*DATA_W +: DATA_W]));
        end
        if (K == KIND_WONLY) begin : g_wo
            // R7: strobe only with a write to this word
            assert_pulse_on_write_R7: assert property (@(posedge clk) disable iff (any_rst)
                wo_pulse[f] |-> (bus_wr && (bus_addr == ADDR_W'(f))));
        end else begin : g_nowo
            // R7: other kinds never strobe
            assert_no_pulse_R7: assert property (@(posedge clk) disable iff (any_rst)
                bus_wr |-> !wo_pulse[f]);
        end
    end

endmodule

bind attr_reg_bank attr_reg_bank_chk #(
    .NUM_FIELDS (NUM_FIELDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .LOCK_IDX   (LOCK_IDX),
    .KIND_MAP   (KIND_MAP)
) u_chk (.*);

// File: tb/attr_reg_bank_test.sv
`timescale 1ns/1ps
module attr_reg_bank_test;

    localparam int NF = 8;
    localparam int DW = 32;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_cold_n = 1'b0;
    logic              rst_warm_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW/8-1:0]   bus_be = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DW-1:0]     bus_rdata;
    logic [NF*DW-1:0]  hw_clr = '0;
    logic [NF*DW-1:0]  hw_set = '0;
    logic [NF*DW-1:0]  field_q;
    logic [NF-1:0]     wo_pulse;
    logic [NF*DW-1:0]  wo_data;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic rd_d  = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    attr_reg_bank uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench copy of the read strobe, to know when a result is due
    always @(posedge clk) rd_d <= bus_rd;

    // monitor: pop one expected item per returned read
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) chk("R9 unexpected read", bus_rdata, '0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    // driver tasks are called at a falling edge and return at one
    task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW/8-1:0] be);
        bus_addr = AW'(a); bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic warm_rst();
        rst_warm_n = 1'b0; repeat (2) @(negedge clk); rst_warm_n = 1'b1;
    endtask

    task automatic cold_rst();
        rst_cold_n = 1'b0; repeat (2) @(negedge clk); rst_cold_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_cold_n = 1'b1; rst_warm_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R10 reset field_q f0", field_q[0 +: DW], 32'hA5);
        rd(0, 32'hA5, "R1 sticky default");
        rd(1, 32'h0, "R2 selfclr reset value");
        rd(9, 32'h0, "R9 unmapped read");
        @(negedge clk);
        chk("R9 idle rdata zero", bus_rdata, '0);

        // sticky and byte enables
        wr(0, 32'h1234_5678, 4'hF);
        rd(0, 32'h1234_5678, "R1 sticky write");
        wr(0, 32'hFFFF_FFFF, 4'b0010);
        rd(0, 32'h1234_FF78, "R8 byte lane 1 only");
        chk("R10 field_q tracks write", field_q[0 +: DW], 32'h1234_FF78);
        wr(1, 32'h0000_00F0, 4'hF);
        warm_rst();
        rd(0, 32'h1234_FF78, "R1 sticky keeps on warm reset");
        rd(1, 32'h0, "R1 non-sticky cleared by warm reset");
        cold_rst();
        rd(0, 32'hA5, "R1 cold reset restores default");

        // self-clearing field
        wr(1, 32'hFF, 4'hF);
        rd(1, 32'hFF, "R2 selfclr write");
        hw_clr[DW + 0] = 1'b1; @(negedge clk); hw_clr = '0;
        rd(1, 32'hFE, "R2 hw clear");
        hw_clr[DW + 1] = 1'b1; wr(1, 32'hFF, 4'hF); hw_clr = '0;
        rd(1, 32'hFD, "R2 clear beats same-cycle write");
        hw_set[DW + 8] = 1'b1; hw_clr[0] = 1'b1; @(negedge clk);
        hw_set = '0; hw_clr = '0;
        rd(1, 32'hFD, "R11 selfclr ignores hw_set");
        rd(0, 32'hA5, "R11 sticky ignores hw_clr");

        // lock word and lockable self-clear
        wr(3, 32'h0F, 4'hF);
        rd(3, 32'h0F, "R4 unlocked write");
        wr(2, 32'h1, 4'hF);
        rd(2, 32'h1, "R3 lock set");
        wr(2, 32'h0, 4'hF);
        rd(2, 32'h1, "R3 lock not cleared by write");
        wr(3, 32'hF0, 4'hF);
        rd(3, 32'h0F, "R4 locked write ignored");
        hw_clr[3*DW + 0] = 1'b1; @(negedge clk); hw_clr = '0;
        rd(3, 32'h0E, "R4 locked field still self-clears");
        warm_rst();
        rd(2, 32'h0, "R3 lock cleared by warm reset");
        wr(3, 32'h33, 4'hF);
        rd(3, 32'h33, "R4 writable after unlock");

        // write-one-to-clear
        hw_set[4*DW +: DW] = 32'h0F; @(negedge clk); hw_set = '0;
        rd(4, 32'h0F, "R5 hw set");
        wr(4, 32'h05, 4'hF);
        rd(4, 32'h0A, "R5 write one clears");
        wr(4, 32'h00, 4'hF);
        rd(4, 32'h0A, "R5 write zero no effect");
        hw_set[4*DW +: DW] = 32'h02; wr(4, 32'h0A, 4'hF); hw_set = '0;
        rd(4, 32'h02, "R5 set beats same-cycle clear");

        // write-once
        wr(5, 32'hFF, 4'h0);
        rd(5, 32'h0, "R6 empty enables ignored");
        wr(5, 32'h11, 4'b0001);
        rd(5, 32'h11, "R6 first write taken");
        wr(5, 32'h22, 4'hF);
        rd(5, 32'h11, "R6 second write ignored");
        warm_rst();
        wr(5, 32'h33, 4'hF);
        rd(5, 32'h33, "R6 writable after reset");

        // write-only
        bus_addr = AW'(6); bus_wdata = 32'hDEAD_BEEF; bus_be = 4'b0011; bus_wr = 1'b1;
        #1;
        chk("R7 pulse during write", {31'b0, wo_pulse[6]}, 32'h1);
        chk("R7 pulse data masked", wo_data[6*DW +: DW], 32'h0000_BEEF);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        #1;
        chk("R7 pulse lasts one cycle", {31'b0, wo_pulse[6]}, 32'h0);
        rd(6, 32'h0, "R7 write-only reads zero");
        chk("R10 write-only field_q zero", field_q[6*DW +: DW], 32'h0);

        // read sharing a cycle with a write returns the old value
        exp_q.push_back(32'h0); tag_q.push_back("R9 read sees pre-write value");
        bus_addr = AW'(7); bus_wdata = 32'h5A5A; bus_be = 4'hF; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
        rd(7, 32'h5A5A, "R9 read after write");
        repeat (3) @(negedge clk);
        chk("R9 idle rdata after reads", bus_rdata, '0);
        chk("R9 all reads returned", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule